// File: doc/BRIEF.md
# Condition Flag Register and Branch Test Unit

This block keeps the four condition flags of a small 8-bit processor core: carry, zero, sign and even parity. Each clock it takes the byte produced by the datapath, the carry-out that came with it, and a 2-bit class code that says what kind of instruction produced them. It then rewrites only the flags that the class is allowed to touch. Data moves write nothing. Increments and decrements leave carry alone. Arithmetic and logic operations rewrite all four flags. Rotates rewrite only carry.

The same block answers branch questions. Conditional jump, call and return logic gives it a 3-bit condition code. The block selects one stored flag and compares it with a wanted polarity. The take/skip bit is a combinational function of the registered flags and the condition code, so branch logic gets an answer in the same cycle it asks.

Top module: `flag_status_unit`

## Requirements
- R1: An active-low asynchronous reset clears all four flags to 0 at once, without waiting for a clock edge.
- R2: Class 2'b00 (load/move) leaves all four flags unchanged, whatever the result and carry inputs are.
- R3: Class 2'b01 (increment/decrement) rewrites zero, sign and parity from the result, and carry keeps its stored value whatever carry_i is.
- R4: Class 2'b10 (arithmetic/logic) rewrites all four flags, and carry takes the value of carry_i.
- R5: Class 2'b11 (rotate) sets carry to carry_i and leaves zero, sign and parity unchanged.
- R6: When zero is written, it becomes 1 exactly when all 8 result bits are 0.
- R7: When sign is written, it becomes result bit 7, where 1 means negative.
- R8: When parity is written, it becomes 1 when the result holds an even number of ones (including none), and 0 otherwise.
- R9: The flag vector is laid out as bit 0 carry, bit 1 zero, bit 2 sign and bit 3 parity. A flag write becomes visible on flags_o after the rising clock edge at which the class is presented.
- R10: cond_i[1:0] picks one flag: 00 carry, 01 zero, 10 sign, 11 parity. cond_true_o is 1 when that flag equals cond_i[2]. It reflects the current registered flags and cond_i with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 8 | Result byte from the datapath |
| carry_i | input | 1 | Carry-out that goes with the result |
| op_class_i | input | 2 | Instruction class: 00 load, 01 inc/dec, 10 ALU, 11 rotate |
| cond_i | input | 3 | Condition code: [1:0] flag select, [2] wanted value |
| flags_o | output | 4 | Stored flags {parity, sign, zero, carry} |
| cond_true_o | output | 1 | Selected flag equals wanted value |

## Verification
The hardest case to show is that carry is preserved across an increment or decrement. That is only visible when the stored carry differs from the carry_i presented in the same cycle. So the stimulus first loads carry to 1 with an arithmetic operation, then issues an increment with carry_i at 0. Masked writes under the load and rotate classes are shown the same way: the bench first puts the flags into a state that the ignored inputs would overturn. A sweep of all eight condition codes over a known flag pattern covers every select and polarity. A long run of random classes and bytes then checks the flags against a reference model held in the bench.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  localparam int unsigned FLAG_N = 4;
  localparam int unsigned SEL_W  = $clog2(FLAG_N);
  localparam int unsigned COND_W = SEL_W + 1;

  // bit positions, also the condition select values
  localparam int unsigned FLAG_CY = 0;
  localparam int unsigned FLAG_ZR = 1;
  localparam int unsigned FLAG_SG = 2;
  localparam int unsigned FLAG_PE = 3;

  typedef enum logic [1:0] {
    CLS_HOLD  = 2'b00,
    CLS_STEP  = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_ROT   = 2'b11
  } op_class_e;

  typedef struct packed {
    logic pe;
    logic sg;
    logic zr;
    logic cy;
  } flags_t;

endpackage

// File: rtl/flag_derive.sv
module flag_derive #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  output logic              zero_o,
  output logic              sign_o,
  output logic              even_o
);

  assign zero_o = ~|result_i;
  assign sign_o = result_i[DATA_W-1];
  assign even_o = ~^result_i;

endmodule

// File: rtl/flag_write_mask.sv
module flag_write_mask
  import flag_unit_pkg::*;
(
  input  op_class_e         op_class_i,
  output logic [FLAG_N-1:0] wr_en_o
);

  always_comb begin
    wr_en_o = '0;
    unique case (op_class_i)
      CLS_HOLD:  wr_en_o = '0;
      CLS_STEP: begin
        wr_en_o[FLAG_ZR] = 1'b1;
        wr_en_o[FLAG_SG] = 1'b1;
        wr_en_o[FLAG_PE] = 1'b1;
      end
      CLS_ARITH: wr_en_o = '1;
      CLS_ROT:   wr_en_o[FLAG_CY] = 1'b1;
      default:   wr_en_o = '0;
    endcase
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_N-1:0] wr_en_i,
  input  logic [FLAG_N-1:0] next_i,
  output logic [FLAG_N-1:0] flags_o
);

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_o[g] <= 1'b0;
      else if (wr_en_i[g]) flags_o[g] <= next_i[g];
    end

    // R2 R3 R5: a flag whose enable is low keeps its value
    a_r2_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i[g] |=> $stable(flags_o[g]));
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_unit_pkg::*;
(
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              take_o
);

  logic [SEL_W-1:0] sel;
  logic             want;

  assign sel    = cond_i[SEL_W-1:0];
  assign want   = cond_i[COND_W-1];
  assign take_o = (flags_i[sel] == want);

endmodule

// File: rtl/flag_status_unit.sv
module flag_status_unit
  import flag_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic [1:0]        op_class_i,
  input  logic [2:0]        cond_i,
  output logic [3:0]        flags_o,
  output logic              cond_true_o
);

  op_class_e         cls;
  logic              zr_d, sg_d, pe_d;
  logic [FLAG_N-1:0] wr_en;
  flags_t            next_f;
  logic [FLAG_N-1:0] flags_q;

  assign cls = op_class_e'(op_class_i);

  flag_derive #(.DATA_W(DATA_W)) u_derive (
    .result_i (result_i),
    .zero_o   (zr_d),
    .sign_o   (sg_d),
    .even_o   (pe_d)
  );

  flag_write_mask u_mask (
    .op_class_i (cls),
    .wr_en_o    (wr_en)
  );

  always_comb begin
    next_f.cy = carry_i;
    next_f.zr = zr_d;
    next_f.sg = sg_d;
    next_f.pe = pe_d;
  end

  flag_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .next_i  (next_f),
    .flags_o (flags_q)
  );

  cond_eval u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .take_o  (cond_true_o)
  );

  assign flags_o = flags_q;

  a_r3_step_keeps_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 2'b01) |=> (flags_o[0] == $past(flags_o[0])));

  a_r4_alu_takes_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 2'b10) |=> (flags_o[0] == $past(carry_i)));

  a_r5_rot_only_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 2'b11) |=> ($stable(flags_o[3:1]) && flags_o[0] == $past(carry_i)));

  a_r6_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 2'b10 && result_i == '0) |=> (flags_o[1] && flags_o[3] && !flags_o[2]));

  a_r7_sign_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 2'b01) |=> (flags_o[2] == $past(result_i[DATA_W-1])));

  // R10: condition code 3'b000 asks for clear carry
  a_r10_carry_clear_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 3'b000) |-> (cond_true_o != flags_o[0]));

endmodule

// File: tb/flag_status_unit_tb.sv
module flag_status_unit_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] result_i = '0;
  logic       carry_i = 1'b0;
  logic [1:0] op_class_i = 2'b00;
  logic [2:0] cond_i = 3'b000;
  logic [3:0] flags_o;
  logic       cond_true_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_f = '0;
  logic [4:0] q_exp[$];
  string      q_tag[$];
  bit         mon_on = 1'b0;

  always #4 clk_i = ~clk_i;

  flag_status_unit u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .result_i    (result_i),
    .carry_i     (carry_i),
    .op_class_i  (op_class_i),
    .cond_i      (cond_i),
    .flags_o     (flags_o),
    .cond_true_o (cond_true_o)
  );

  // reference: bit0 carry, bit1 zero, bit2 sign, bit3 even parity
  function automatic logic [3:0] ref_next(logic [3:0] f, logic [1:0] c, logic [7:0] r, logic cy);
    logic [3:0] n;
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    n = f;
    if (c == 2'b01 || c == 2'b10) begin
      n[1] = (r == 8'h00);
      n[2] = r[7];
      n[3] = (ones % 2 == 0);
    end
    if (c == 2'b10 || c == 2'b11) n[0] = cy;
    return n;
  endfunction

  function automatic logic ref_cond(logic [3:0] f, logic [2:0] c);
    return f[c[1:0]] == c[2];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [1:0] c, logic [7:0] r, logic cy, logic [2:0] cc, string tag);
    @(negedge clk_i);
    op_class_i = c;
    result_i   = r;
    carry_i    = cy;
    cond_i     = cc;
    model_f    = ref_next(model_f, c, r, cy);
    q_exp.push_back({ref_cond(model_f, cc), model_f});
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    logic [4:0] e;
    string t;
    forever begin
      @(posedge clk_i);
      #2;
      if (mon_on && q_exp.size() > 0) begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({t, " flags"}, {28'd0, flags_o}, {28'd0, e[3:0]});
        check("R10 cond", {31'd0, cond_true_o}, {31'd0, e[4]});
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin : driver
    string tags[4];
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
    #3;
    check("R1 reset flags", {28'd0, flags_o}, 32'd0);
    #10 rst_ni = 1'b1;
    mon_on = 1'b1;

    step(2'b10, 8'h00, 1'b1, 3'b101, "R6 R8 R4 zero result");  // expect 1011
    step(2'b00, 8'hFF, 1'b0, 3'b000, "R2 load holds");
    step(2'b01, 8'h80, 1'b0, 3'b110, "R3 R7 carry kept");      // expect 0101
    step(2'b11, 8'h00, 1'b0, 3'b100, "R5 rotate carry only");  // expect 0100
    step(2'b10, 8'h03, 1'b0, 3'b111, "R8 even two ones");      // expect 1000
    step(2'b01, 8'h01, 1'b1, 3'b011, "R8 odd one");            // expect 0000
    step(2'b10, 8'hFE, 1'b1, 3'b010, "R9 layout");             // expect 0101
    // R10 sweep of every code over pattern 0101
    for (int k = 0; k < 8; k++) step(2'b00, 8'h00, 1'b1, 3'(k), "R10 sweep hold");

    for (int n = 0; n < 600; n++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 3));
      step(c, 8'($urandom), 1'($urandom), 3'($urandom), tags[c]);
    end

    wait (q_exp.size() == 0);
    @(negedge clk_i);
    step(2'b10, 8'h81, 1'b1, 3'b000, "R4 pre-reset");  // flags nonzero
    wait (q_exp.size() == 0);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 check("R1 async clear", {28'd0, flags_o}, 32'd0);
    model_f = '0;
    #3 rst_ni = 1'b1;
    step(2'b00, 8'h00, 1'b1, 3'b000, "R1 after reset");
    wait (q_exp.size() == 0);
    @(negedge clk_i);
    finish_run();
  end

endmodule